// File: doc/BRIEF.md
# Seconds Alarm Comparator

This block stores a 32-bit alarm time and compares it, once per clock, with a free-running seconds count supplied from outside. Software programs the alarm through a byte-wide register port, sets an enable bit, and waits for the interrupt line. When the enable is set and the count equals the stored time, a pending flag latches. The interrupt output is that flag, so the consumer sees one rising edge per alarm.

The flag is sticky. Dropping the enable bit does not clear it. Software clears it by writing a one to a strobe bit in a second control register. A read-only identification byte lets software recognise the block. Software erases the stored alarm time by writing zero to every byte of it.

Top module: `alarm_compare`

## Requirements
- R1: After reset, the four alarm-time bytes and the first control register read 0x00, and `alarm_irq` is low.
- R2: The alarm time sits at addresses 0x40 to 0x43 in little-endian order: 0x40 holds bits 7:0 and 0x43 holds bits 31:24. Each byte can be written on its own and reads back the value last written. Writing 0x00 to all four bytes leaves the stored time at zero.
- R3: The first control register is at 0x46. Bit 7 is the alarm enable and bit 0 is the abort enable. Writes to bits 6:1 are ignored, and those bits read as zero.
- R4: If, at a clock edge, the enable bit is 1 and `sec_count` equals the stored alarm time, `alarm_irq` is high from that edge onward. Setting the enable while the count already matches raises `alarm_irq` one clock after the enable write.
- R5: Only an exact match sets the flag. A count one above or one below the alarm time, or a match while the enable bit is 0, leaves `alarm_irq` low.
- R6: Once `alarm_irq` is high it stays high, even after the enable bit is cleared, until it is cleared as in R7.
- R7: The second control register is at 0x48. A write with bit 0 set drops `alarm_irq` at that write's clock edge. A write with bit 0 clear has no effect. The register always reads 0x00.
- R8: A clear takes priority over a match in the same cycle. If the enable is still set and the count still matches, the flag sets again on the next clock.
- R9: Address 0x05 reads 0x03. Any other address outside the registers above reads 0x00, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sec_count | input | 32 | Seconds count to compare against |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| alarm_irq | output | 1 | Pending-alarm interrupt, level high |

## Verification
The assertions assume that `sec_count` is synchronous to `clk` and that each write lasts exactly one cycle with its address and data held stable. They also assume the read address is meaningful in every cycle, because read data is combinational. The stimulus drives every input on the falling edge and returns `reg_wr` low after one cycle. It moves `sec_count` only while the enable is off or while a match is intended, so every rise of the interrupt is one the bench planned.

// File: rtl/alarm_compare.sv
module alarm_compare #(
  parameter int CNT_W      = 32,
  parameter int ADDR_W     = 8,
  parameter logic [7:0] ID_VAL = 8'h03,
  parameter logic [ADDR_W-1:0] ID_ADDR    = 8'h05,
  parameter logic [ADDR_W-1:0] ALM_BASE   = 8'h40,
  parameter logic [ADDR_W-1:0] CTRL1_ADDR = 8'h46,
  parameter logic [ADDR_W-1:0] CTRL2_ADDR = 8'h48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  sec_count,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              alarm_irq
);

  localparam int NB = CNT_W / 8;

  logic [7:0]       alm_b [NB];
  logic [CNT_W-1:0] alarm_val;
  logic             en_q, abort_q, pend_q;
  logic             wr_ctrl1, clr_stb, hit;

  assign wr_ctrl1 = reg_wr && (reg_addr == CTRL1_ADDR);
  assign clr_stb  = reg_wr && (reg_addr == CTRL2_ADDR) && reg_wdata[0];
  assign hit      = en_q && (sec_count == alarm_val);

  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        alm_b[b] <= 8'h00;
      else if (reg_wr && (reg_addr == ALM_BASE + ADDR_W'(b)))
        alm_b[b] <= reg_wdata;
    assign alarm_val[8*b +: 8] = alm_b[b];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q    <= 1'b0;
      abort_q <= 1'b0;
    end else if (wr_ctrl1) begin
      en_q    <= reg_wdata[7];
      abort_q <= reg_wdata[0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      pend_q <= 1'b0;
    else if (clr_stb) pend_q <= 1'b0;
    else if (hit)     pend_q <= 1'b1;

  assign alarm_irq = pend_q;

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr == ID_ADDR)    reg_rdata = ID_VAL;
    if (reg_addr == CTRL1_ADDR) reg_rdata = {en_q, 6'b0, abort_q};
    for (int b = 0; b < NB; b++)
      if (reg_addr == ALM_BASE + ADDR_W'(b)) reg_rdata = alm_b[b];
  end

  AST_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && sec_count == alarm_val && !clr_stb) |=> alarm_irq); // R4
  AST_RISE_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_irq) |-> $past(en_q && sec_count == alarm_val)); // R5
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_irq && !clr_stb) |=> alarm_irq); // R6
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> !alarm_irq); // R7
  AST_CTRL2_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == CTRL2_ADDR) |-> (reg_rdata == 8'h00)); // R7
  AST_CTRL1_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == CTRL1_ADDR) |-> (reg_rdata[6:1] == 6'b0)); // R3

endmodule

// File: tb/tb_alarm_compare.sv
`timescale 1ns/1ps
module tb_alarm_compare;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] sec_count = '0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        alarm_irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  alarm_compare dut (
    .clk(clk), .rst_n(rst_n), .sec_count(sec_count),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .alarm_irq(alarm_irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic set_alarm(input logic [31:0] v);
    for (int b = 0; b < 4; b++) wr(8'h40 + 8'(b), v[8*b +: 8]);
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [31:0] vals [6];
    vals[0] = 32'h0; vals[1] = 32'h1; vals[2] = 32'h000000FF;
    vals[3] = 32'h12345678; vals[4] = 32'hFFFFFFFF; vals[5] = 32'h80000000;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq", {31'b0, alarm_irq}, 0);
    for (int b = 0; b < 4; b++) begin rd(8'h40 + 8'(b), d); chk("R1 alarm byte", d, 0); end
    rd(8'h46, d); chk("R1 ctrl1", d, 0);

    for (int b = 0; b < 4; b++)
      for (int p = 0; p < 8; p++) begin
        logic [7:0] pat;
        pat = 8'(p * 37 + 1) ^ {p[0], 7'b0};
        wr(8'h40 + 8'(b), pat);
        rd(8'h40 + 8'(b), d); chk("R2 byte readback", d, pat);
      end
    set_alarm(32'hA1B2C3D4);
    for (int b = 0; b < 4; b++) begin
      logic [31:0] w;
      w = 32'hA1B2C3D4;
      rd(8'h40 + 8'(b), d); chk("R2 little-endian", d, w[8*b +: 8]);
    end
    set_alarm(32'h0);
    for (int b = 0; b < 4; b++) begin rd(8'h40 + 8'(b), d); chk("R2 zero clear", d, 0); end

    wr(8'h46, 8'hFF); rd(8'h46, d); chk("R3 ctrl1 reserved", d, 8'h81);
    wr(8'h46, 8'h01); rd(8'h46, d); chk("R3 abort only", d, 8'h01);
    wr(8'h46, 8'h7E); rd(8'h46, d); chk("R3 middle bits", d, 8'h00);

    rd(8'h05, d); chk("R9 id", d, 8'h03);
    set_alarm(32'h11223344);
    foreach (vals[i]) begin
      logic [7:0] a;
      a = (i == 0) ? 8'h44 : (i == 1) ? 8'h47 : (i == 2) ? 8'h00 : (i == 3) ? 8'h3F : (i == 4) ? 8'h49 : 8'hFF;
      wr(a, 8'hFF);
      rd(a, d); chk("R9 unmapped read", d, 0);
    end
    for (int b = 0; b < 4; b++) begin
      logic [31:0] w;
      w = 32'h11223344;
      rd(8'h40 + 8'(b), d); chk("R9 no side effect", d, w[8*b +: 8]);
    end
    rd(8'h46, d); chk("R9 ctrl1 untouched", d, 0);

    foreach (vals[i]) begin
      set_alarm(vals[i]);
      for (int off = -2; off <= 2; off++) begin
        wr(8'h46, 8'h00);
        wr(8'h48, 8'h01);
        sec_count = vals[i] + 32'(off);
        wr(8'h46, 8'h80);
        chk("R4 latency", {31'b0, alarm_irq}, 0);
        @(negedge clk);
        chk(off == 0 ? "R4 match" : "R5 near miss", {31'b0, alarm_irq}, (off == 0) ? 1 : 0);
      end
      wr(8'h46, 8'h00); wr(8'h48, 8'h01);
      sec_count = vals[i];
      repeat (3) @(negedge clk);
      chk("R5 disabled match", {31'b0, alarm_irq}, 0);
    end

    set_alarm(32'h0000BEEF);
    sec_count = 32'h0000BEEF;
    wr(8'h46, 8'h80);
    @(negedge clk);
    chk("R4 set", {31'b0, alarm_irq}, 1);
    wr(8'h46, 8'h00);
    sec_count = 32'h5;
    repeat (4) @(negedge clk);
    chk("R6 sticky", {31'b0, alarm_irq}, 1);
    wr(8'h48, 8'hFE);
    chk("R7 bit0 clear no effect", {31'b0, alarm_irq}, 1);
    rd(8'h48, d); chk("R7 reads zero", d, 0);
    wr(8'h48, 8'h01);
    chk("R7 clear", {31'b0, alarm_irq}, 0);
    rd(8'h48, d); chk("R7 reads zero after", d, 0);

    sec_count = 32'h0000BEEF;
    wr(8'h46, 8'h80);
    @(negedge clk);
    chk("R8 armed", {31'b0, alarm_irq}, 1);
    wr(8'h48, 8'h01);
    chk("R8 clear wins", {31'b0, alarm_irq}, 0);
    @(negedge clk);
    chk("R8 re-set", {31'b0, alarm_irq}, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule